// File: doc/BRIEF.md
# A20 Address Gate and Warm Reset Command Decoder

This block sits on a simple host I/O write port and watches for the legacy command sequences that open or close the address-bit-20 gate and request a warm reset of the processor. A two-step sequence drives the gate. A command byte written to the controller command port arms the block. A data byte then written to the controller data port sets or clears the gate. A single write of a reset-class command byte to the command port starts a reset pulse of fixed length.

A second, faster control path is a system control port. A write to it sets the gate directly from one data bit and can start the same reset pulse from another bit. A reserved read of that port returns the gate level the block is driving. A mode input enables the keyboard-controller path alone, the system control path alone, or both. When both are enabled, the gate is open if either path has opened it.

The block's outputs are the gate level, the incoming address bit 20 masked by that gate, and the processor reset. All host signals are plain strobes. Every write strobe is taken in the cycle it is presented, and the block never applies back-pressure.

Top module: `a20_gate_emu`

## Requirements
- R1: After reset is released, the gate is closed (`a20_en_o` = 0), `cpu_rst_o` is 0, and the command sequence is not armed.
- R2: With the keyboard path enabled (mode 00, 10 or 11), a write of D1h to port 64h arms the block. A following write of 02h to port 60h opens the gate. `a20_en_o` is 1 from the cycle after that write.
- R3: When armed, a write of 00h to port 60h closes the gate from the cycle after that write. Any other data byte leaves the gate unchanged. Any port 60h write clears the armed state.
- R4: Any port 64h write whose data is not D1h clears the armed state. A port 60h write that is not armed has no effect on the gate.
- R5: A port 64h write with the keyboard path enabled, whose data matches 1111xxx0b (data AND F1h equals F0h), raises `cpu_rst_o` from the next cycle for exactly 16 cycles. Data such as EFh or 7Eh raises no pulse.
- R6: With the system control path enabled (mode 01, 10 or 11), a write to port 92h loads that path's gate from data bit 1. A write with data bit 0 = 1 starts the same 16-cycle reset pulse.
- R7: With `io_addr_i` = 0092h, `io_rdata_o` carries the level of `a20_en_o` in bit 1, with every other bit 0. For any other address, `io_rdata_o` is 00h.
- R8: Mode 00 ignores port 92h writes: that path's gate and the reset are both left unchanged. Mode 01 ignores port 60h and 64h writes. Mode 10 or 11 drives `a20_en_o` as the OR of both gates. A disabled path's gate has no effect on `a20_en_o`.
- R9: `a20_o` equals `a20_in_i` AND `a20_en_o` in every cycle.
- R10: A new reset trigger while a pulse is active restarts the count, so that `cpu_rst_o` stays high for 16 cycles after the new trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Path select: 00 keyboard path, 01 system control port, 10/11 both |
| io_addr_i | input | 16 | Host I/O address |
| io_wdata_i | input | 8 | Host write data |
| io_wr_i | input | 1 | Write strobe, one cycle per write |
| io_rdata_o | output | 8 | Read data for the system control port |
| a20_in_i | input | 1 | Address bit 20 from the processor |
| a20_o | output | 1 | Address bit 20 after the gate |
| a20_en_o | output | 1 | Effective gate level |
| cpu_rst_o | output | 1 | Processor warm reset pulse |

## Verification
The bench drives the armed flag and both gate registers through command sequences, and each has a visible result at the ports. A lost or stuck arm shows as a gate level that is wrong one cycle after the port 60h write. A gate latched on the disabled path shows as soon as the mode is switched, either on `a20_en_o` or in the port 92h read data. A reset counter that is off by one shows on the sixteenth or seventeenth cycle of the pulse. A failed restart shows sixteen cycles after the second trigger.

// File: rtl/a20_pkg.sv
package a20_pkg;
  typedef enum logic [1:0] {
    MODE_KBC  = 2'b00,
    MODE_FAST = 2'b01,
    MODE_BOTH = 2'b10
  } a20_mode_e;

  localparam int unsigned IO_AW = 16;
  localparam int unsigned IO_DW = 8;
  localparam logic [IO_AW-1:0] PORT_KDATA = 16'h0060;
  localparam logic [IO_AW-1:0] PORT_KCMD  = 16'h0064;
  localparam logic [IO_AW-1:0] PORT_SYSC  = 16'h0092;
  localparam logic [IO_DW-1:0] CMD_WROUT  = 8'hD1;
  localparam logic [IO_DW-1:0] DAT_OPEN   = 8'h02;
  localparam logic [IO_DW-1:0] DAT_CLOSE  = 8'h00;
  localparam logic [IO_DW-1:0] RST_MASK   = 8'hF1;
  localparam logic [IO_DW-1:0] RST_MATCH  = 8'hF0;
  localparam int unsigned SYSC_GATE_BIT = 1;
  localparam int unsigned SYSC_RST_BIT  = 0;
endpackage

// File: rtl/a20_kbc_seq.sv
module a20_kbc_seq
  import a20_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             wr_i,
  input  logic [IO_AW-1:0] addr_i,
  input  logic [IO_DW-1:0] data_i,
  output logic             gate_o,
  output logic             rst_trig_o
);
  logic armed_q, gate_q;
  logic cmd_wr, dat_wr;

  assign cmd_wr = en_i && wr_i && (addr_i == PORT_KCMD);
  assign dat_wr = en_i && wr_i && (addr_i == PORT_KDATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      gate_q  <= 1'b0;
    end else begin
      if (cmd_wr) begin
        armed_q <= (data_i == CMD_WROUT);
      end else if (dat_wr) begin
        armed_q <= 1'b0;
        if (armed_q) begin
          if (data_i == DAT_OPEN)       gate_q <= 1'b1;
          else if (data_i == DAT_CLOSE) gate_q <= 1'b0;
        end
      end
    end
  end

  assign gate_o     = gate_q;
  assign rst_trig_o = cmd_wr && ((data_i & RST_MASK) == RST_MATCH);

  // R2
  open_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && dat_wr && data_i == DAT_OPEN) |=> gate_q);
  // R4
  disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && data_i != CMD_WROUT) |=> !armed_q);
  // R4
  unarmed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !cmd_wr) |=> $stable(gate_q));
endmodule

// File: rtl/a20_sysc_port.sv
module a20_sysc_port
  import a20_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             wr_i,
  input  logic [IO_AW-1:0] addr_i,
  input  logic [1:0]       data_i,
  output logic             gate_o,
  output logic             rst_trig_o
);
  logic gate_q, sel_wr;

  assign sel_wr = en_i && wr_i && (addr_i == PORT_SYSC);

  always_ff @(posedge clk) begin
    if (!rst_n)      gate_q <= 1'b0;
    else if (sel_wr) gate_q <= data_i[SYSC_GATE_BIT];
  end

  assign gate_o     = gate_q;
  assign rst_trig_o = sel_wr && data_i[SYSC_RST_BIT];

  // R8
  ignored_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i) |=> $stable(gate_q));
endmodule

// File: rtl/a20_rst_pulse.sv
module a20_rst_pulse #(
  parameter int unsigned PULSE_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic rst_o
);
  localparam int unsigned CW = $clog2(PULSE_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_CYC);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (trig_i)           cnt_q <= LOAD;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign rst_o = (cnt_q != '0);

  // R5
  trig_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i |=> rst_o);
  // R10
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOAD);
  // R5
  countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_o && !trig_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/a20_gate_emu.sv
module a20_gate_emu
  import a20_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  mode_i,
  input  logic [15:0] io_addr_i,
  input  logic [7:0]  io_wdata_i,
  input  logic        io_wr_i,
  output logic [7:0]  io_rdata_o,
  input  logic        a20_in_i,
  output logic        a20_o,
  output logic        a20_en_o,
  output logic        cpu_rst_o
);
  logic kbc_on, sysc_on;
  logic kbc_gate, kbc_trig, sysc_gate, sysc_trig;

  always_comb begin
    kbc_on  = (mode_i != MODE_FAST);
    sysc_on = (mode_i != MODE_KBC);
  end

  a20_kbc_seq i_kbc (
    .clk(clk), .rst_n(rst_n), .en_i(kbc_on), .wr_i(io_wr_i),
    .addr_i(io_addr_i), .data_i(io_wdata_i),
    .gate_o(kbc_gate), .rst_trig_o(kbc_trig)
  );

  a20_sysc_port i_sysc (
    .clk(clk), .rst_n(rst_n), .en_i(sysc_on), .wr_i(io_wr_i),
    .addr_i(io_addr_i), .data_i(io_wdata_i[1:0]),
    .gate_o(sysc_gate), .rst_trig_o(sysc_trig)
  );

  a20_rst_pulse #(.PULSE_CYC(PULSE_CYC)) i_pulse (
    .clk(clk), .rst_n(rst_n), .trig_i(kbc_trig || sysc_trig), .rst_o(cpu_rst_o)
  );

  always_comb begin
    a20_en_o = (kbc_on && kbc_gate) || (sysc_on && sysc_gate);
    a20_o    = a20_in_i && a20_en_o;
    io_rdata_o = '0;
    if (io_addr_i == PORT_SYSC) io_rdata_o[SYSC_GATE_BIT] = a20_en_o;
  end

  // R9
  mask_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!a20_en_o) |-> !a20_o);
  // R8
  fast_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_FAST) |-> (a20_en_o == sysc_gate));
  // R8
  kbc_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_KBC) |-> (a20_en_o == kbc_gate));
endmodule

// File: tb/test_a20_gate_emu.sv
module test_a20_gate_emu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b10;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr = 1'b0;
  logic [7:0]  rdata;
  logic        a20_in = 1'b1;
  logic        a20_out, a20_en, cpu_rst;
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #2.5 clk = ~clk;

  a20_gate_emu i_a20_gate_emu (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .io_addr_i(addr),
    .io_wdata_i(wdata), .io_wr_i(wr), .io_rdata_o(rdata),
    .a20_in_i(a20_in), .a20_o(a20_out), .a20_en_o(a20_en), .cpu_rst_o(cpu_rst)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0; addr = 16'h0000;
  endtask

  task automatic do_reset;
    rst_n = 1'b0; mode = 2'b10;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  // count consecutive high samples of cpu_rst starting now
  task automatic pulse_len(output int len);
    len = 0;
    while (cpu_rst && len < 40) begin len++; @(negedge clk); end
  endtask

  task automatic t_reset_state;
    do_reset();
    check(a20_en == 0, "R1 gate", a20_en, 0);
    check(cpu_rst == 0, "R1 rst", cpu_rst, 0);
    io_write(16'h0060, 8'h02);
    check(a20_en == 0, "R1 not armed", a20_en, 0);
  endtask

  task automatic t_kbc_open_close;
    do_reset(); mode = 2'b00;
    io_write(16'h0064, 8'hD1); io_write(16'h0060, 8'h02);
    check(a20_en == 1, "R2 open", a20_en, 1);
    io_write(16'h0064, 8'hD1); io_write(16'h0060, 8'h55);
    check(a20_en == 1, "R3 other data keeps", a20_en, 1);
    io_write(16'h0060, 8'h00);
    check(a20_en == 1, "R3 arm cleared by data write", a20_en, 1);
    io_write(16'h0064, 8'hD1); io_write(16'h0060, 8'h00);
    check(a20_en == 0, "R3 close", a20_en, 0);
  endtask

  task automatic t_disarm;
    do_reset(); mode = 2'b00;
    io_write(16'h0064, 8'hD1); io_write(16'h0064, 8'hAA); io_write(16'h0060, 8'h02);
    check(a20_en == 0, "R4 disarmed by other cmd", a20_en, 0);
    check(cpu_rst == 0, "R4 AA no reset", cpu_rst, 0);
  endtask

  task automatic t_fast_reset;
    int len;
    do_reset(); mode = 2'b00;
    io_write(16'h0064, 8'hFE); pulse_len(len);
    check(len == 16, "R5 FE pulse length", len, 16);
    io_write(16'h0064, 8'hF0); pulse_len(len);
    check(len == 16, "R5 F0 pulse length", len, 16);
    io_write(16'h0064, 8'hEF);
    check(cpu_rst == 0, "R5 EF no pulse", cpu_rst, 0);
    io_write(16'h0064, 8'h7E);
    check(cpu_rst == 0, "R5 7E no pulse", cpu_rst, 0);
    io_write(16'h0064, 8'hFF);
    check(cpu_rst == 0, "R5 FF no pulse", cpu_rst, 0);
  endtask

  task automatic t_sysc;
    int len;
    do_reset(); mode = 2'b01;
    io_write(16'h0092, 8'h02);
    check(a20_en == 1, "R6 sysc open", a20_en, 1);
    io_write(16'h0092, 8'h03); pulse_len(len);
    check(len == 16, "R6 sysc pulse", len, 16);
    check(a20_en == 1, "R6 gate after pulse write", a20_en, 1);
    io_write(16'h0092, 8'h00);
    check(a20_en == 0, "R6 sysc close", a20_en, 0);
  endtask

  task automatic t_read;
    do_reset(); mode = 2'b01;
    @(negedge clk); addr = 16'h0092; #1;
    check(rdata == 8'h00, "R7 read closed", rdata, 0);
    io_write(16'h0092, 8'h02);
    addr = 16'h0092; #1;
    check(rdata == 8'h02, "R7 read open", rdata, 2);
    addr = 16'h0064; #1;
    check(rdata == 8'h00, "R7 other address", rdata, 0);
    addr = 16'h0000;
  endtask

  task automatic t_modes;
    do_reset(); mode = 2'b00;
    io_write(16'h0092, 8'h03);
    check(cpu_rst == 0, "R8 mode00 ignores 92 reset", cpu_rst, 0);
    check(a20_en == 0, "R8 mode00 ignores 92 gate", a20_en, 0);
    mode = 2'b01; #1;
    check(a20_en == 0, "R8 92 gate not latched in mode00", a20_en, 0);
    io_write(16'h0064, 8'hD1); io_write(16'h0060, 8'h02); io_write(16'h0064, 8'hFE);
    check(cpu_rst == 0, "R8 mode01 ignores 64 reset", cpu_rst, 0);
    mode = 2'b00; #1;
    check(a20_en == 0, "R8 kbc gate not latched in mode01", a20_en, 0);
    io_write(16'h0064, 8'hD1); io_write(16'h0060, 8'h02);
    mode = 2'b01; #1;
    check(a20_en == 0, "R8 mode01 hides kbc gate", a20_en, 0);
    mode = 2'b11; #1;
    check(a20_en == 1, "R8 both OR kbc", a20_en, 1);
    io_write(16'h0064, 8'hD1); io_write(16'h0060, 8'h00);
    io_write(16'h0092, 8'h02);
    check(a20_en == 1, "R8 both OR sysc", a20_en, 1);
    io_write(16'h0092, 8'h00);
    check(a20_en == 0, "R8 both closed", a20_en, 0);
  endtask

  task automatic t_mask;
    do_reset(); mode = 2'b10;
    a20_in = 1'b1; #1;
    check(a20_out == 0, "R9 masked low", a20_out, 0);
    io_write(16'h0092, 8'h02);
    check(a20_out == 1, "R9 passes high", a20_out, 1);
    a20_in = 1'b0; #1;
    check(a20_out == 0, "R9 passes low", a20_out, 0);
    a20_in = 1'b1;
  endtask

  task automatic t_retrigger;
    int len;
    do_reset(); mode = 2'b10;
    io_write(16'h0064, 8'hFE);
    repeat (5) @(negedge clk);
    io_write(16'h0092, 8'h01); pulse_len(len);
    check(len == 16, "R10 restart length", len, 16);
  endtask

  initial begin
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    t_reset_state();
    t_kbc_open_close();
    t_disarm();
    t_fast_reset();
    t_sysc();
    t_read();
    t_modes();
    t_mask();
    t_retrigger();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule